// File: doc/BRIEF.md
# Idle-Timeout DRAM Low-Power Controller

The controller watches the memory request port. When no access has arrived for a programmed number of clock cycles, it puts the attached SDRAM into one of three low-power states: clock stop, self-refresh or power-down. A new access brings the memory back to the active state. The exit runs in a fixed order. First comes a programmable exit-wait count, which stands in for the device's exit timing. After a power-down exit a long impedance-calibration handshake follows. Only then is the access granted.

Each mode has its own raw timeout in cycles. The block encodes each raw timeout into a 4-bit field and runs its idle timer from the encoded value. The encoded fields, together with the effective mode, are presented on a packed configuration word. Two parameters select hardware variants:

- One variant forbids power-down and substitutes self-refresh for it.
- One variant has no clock-stop timeout field.

A pending frequency change holds off self-refresh entry only.

The state machine has four states:

- `ST_ACTIVE`: accesses are granted and the idle timer runs.
- `ST_LOWPWR`: the memory is in the mode latched at entry.
- `ST_EXIT_WAIT`: the exit-wait count runs down.
- `ST_ZQ_CAL`: the block waits for the calibration engine.

Its transitions are:

- ACTIVE→LOWPWR on timer expiry with low power enabled and not held off.
- LOWPWR→EXIT_WAIT on an access request.
- EXIT_WAIT→ACTIVE when the count is spent, unless the latched mode was power-down.
- EXIT_WAIT→ZQ_CAL when the count is spent and the latched mode was power-down.
- ZQ_CAL→ACTIVE on calibration done.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (ACTIVE), all enter, exit and `zq_req_o` outputs are 0, and `grant_o` is 0 while `req_i` is 0.
- R2: Each encoded field is ceil(log2(raw)) − 3. A raw value below 16 encodes as 0, and any result above 15 saturates at 15. The fields sit in `cfg_o` as follows: clock stop [3:0], self-refresh [7:4], effective mode [10:8], power-down [15:12], and bit 11 reads 0.
- R3: With a mode enabled, the matching enter pulse is asserted combinationally in the cycle that completes 2^(code+3) consecutive idle cycles. The code used is the field of the selected mode. The state becomes LOWPWR on the next edge.
- R4: Any cycle with `req_i` high restarts the idle count from zero.
- R5: With mode code 0, or an unused code (3, 5, 6, 7), the block never leaves ACTIVE and issues no enter pulse.
- R6: In LOWPWR, `req_i` produces the exit pulse of the latched mode in the same cycle. It is followed by `exit_wait_i`+1 cycles in EXIT_WAIT without grant. For clock stop and self-refresh, `grant_o` first rises in cycle `exit_wait_i`+2 after the exit pulse.
- R7: After a power-down exit wait, `zq_req_o` is held and `grant_o` stays low until `zq_done_i` is seen. The block is ACTIVE on the following edge.
- R8: While `freq_chg_i` is high, self-refresh entry is suppressed. Entry follows in the same cycle that `freq_chg_i` falls if the timer has expired. Clock-stop entry is not affected.
- R9: With `PD_BLOCKED`=1, a power-down request (code 4) becomes self-refresh (code 2): `cfg_o[10:8]` reads 2, the self-refresh timeout applies and `enter_sr_o` is issued.
- R10: With `NO_CS_FIELD`=1, `cfg_o[3:0]` reads 0 and clock stop uses code 0.
- R11: The mode codes are 1 for clock stop, 2 for self-refresh and 4 for power-down. The `state_o` codes are ACTIVE 0, LOWPWR 1, EXIT_WAIT 2, ZQ_CAL 3. At most one enter or exit pulse is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested low-power mode code |
| cs_cycles_i | input | TMO_W | Raw clock-stop idle timeout in cycles |
| sr_cycles_i | input | TMO_W | Raw self-refresh idle timeout in cycles |
| pd_cycles_i | input | TMO_W | Raw power-down idle timeout in cycles |
| exit_wait_i | input | WAIT_W | Exit-wait count loaded on each exit |
| req_i | input | 1 | Memory access request |
| freq_chg_i | input | 1 | Frequency change pending |
| zq_done_i | input | 1 | Calibration engine finished |
| grant_o | output | 1 | Access granted |
| enter_cs_o | output | 1 | Enter clock stop |
| exit_cs_o | output | 1 | Exit clock stop |
| enter_sr_o | output | 1 | Enter self-refresh |
| exit_sr_o | output | 1 | Exit self-refresh |
| enter_pd_o | output | 1 | Enter power-down |
| exit_pd_o | output | 1 | Exit power-down |
| zq_req_o | output | 1 | Long calibration request |
| state_o | output | 3 | Current state code |
| cfg_o | output | 16 | Effective mode and encoded timeout fields |

## Verification
The hardest case to reach is the coincidence the self-refresh guard exists for. The idle timer must already have expired while a frequency change is still pending, and the entry must then fire in exactly the cycle the change is released. The stimulus holds `freq_chg_i` high through far more idle cycles than the timeout. It confirms that no entry occurs, then drops the request at a falling edge and samples the enter pulse in that same cycle. The power-down calibration path is reached by entering power-down and exiting it. The `zq_done_i` response is delayed so that the blocked-grant window is several cycles wide.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = (1 << CODE_W) + 3;

    localparam logic [2:0] MODE_OFF     = 3'd0;
    localparam logic [2:0] MODE_CLKSTOP = 3'd1;
    localparam logic [2:0] MODE_SELFREF = 3'd2;
    localparam logic [2:0] MODE_PWRDN   = 3'd4;

    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_LOWPWR    = 3'd1,
        ST_EXIT_WAIT = 3'd2,
        ST_ZQ_CAL    = 3'd3
    } lp_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] pd;
        logic              rsvd;
        logic [2:0]        mode;
        logic [CODE_W-1:0] sr;
        logic [CODE_W-1:0] cs;
    } lp_cfg_t;
endpackage

// File: rtl/lp_tmo_enc.sv
module lp_tmo_enc
    import lp_pkg::*;
#(
    parameter int TMO_W = 20
) (
    input  logic [TMO_W-1:0]  raw_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    logic [TMO_W:0] pow_v;
    int             n_v;

    always_comb begin
        n_v = 0;
        for (int i = 0; i < TMO_W; i++) begin
            pow_v    = '0;
            pow_v[i] = 1'b1;
            if (pow_v < {1'b0, raw_i}) n_v = i + 1;
        end
        if (raw_i < TMO_W'(16))
            code_o = '0;
        else if ((n_v - 3) > CODE_MAX)
            code_o = CODE_W'(CODE_MAX);
        else
            code_o = CODE_W'(n_v - 3);
    end
endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer
    import lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              req_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              expired_o
);
    logic [CNT_W-1:0] idle_q;
    logic [CNT_W-1:0] lim_m1;
    logic [4:0]       shamt;

    assign shamt  = {1'b0, code_i} + 5'd3;
    assign lim_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idle_q <= '0;
        else if (!run_i || req_i)
            idle_q <= '0;
        else if (idle_q < lim_m1)
            idle_q <= idle_q + CNT_W'(1);
    end

    assign expired_o = run_i && !req_i && (idle_q >= lim_m1);
endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl
    import lp_pkg::*;
#(
    parameter int TMO_W       = 20,
    parameter int WAIT_W      = 8,
    parameter bit PD_BLOCKED  = 1'b0,
    parameter bit NO_CS_FIELD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [TMO_W-1:0]  cs_cycles_i,
    input  logic [TMO_W-1:0]  sr_cycles_i,
    input  logic [TMO_W-1:0]  pd_cycles_i,
    input  logic [WAIT_W-1:0] exit_wait_i,
    input  logic              req_i,
    input  logic              freq_chg_i,
    input  logic              zq_done_i,
    output logic              grant_o,
    output logic              enter_cs_o,
    output logic              exit_cs_o,
    output logic              enter_sr_o,
    output logic              exit_sr_o,
    output logic              enter_pd_o,
    output logic              exit_pd_o,
    output logic              zq_req_o,
    output logic [2:0]        state_o,
    output logic [15:0]       cfg_o
);
    localparam int N_TMO = 3;

    lp_state_e         state_q, state_d;
    logic [2:0]        lp_mode_q;
    logic [WAIT_W-1:0] wait_q;
    logic [2:0]        eff_mode;
    logic [TMO_W-1:0]  raw_arr  [N_TMO];
    logic [CODE_W-1:0] code_arr [N_TMO];
    logic [CODE_W-1:0] cs_code, sel_code;
    logic              lp_en, expired, go_lp;
    lp_cfg_t           cfg;

    assign raw_arr[0] = cs_cycles_i;
    assign raw_arr[1] = sr_cycles_i;
    assign raw_arr[2] = pd_cycles_i;

    // One encoder per mode timeout
    for (genvar g = 0; g < N_TMO; g++) begin : g_enc
        lp_tmo_enc #(.TMO_W(TMO_W)) u_enc (
            .raw_i  (raw_arr[g]),
            .code_o (code_arr[g])
        );
    end

    // Variant without a clock-stop field reads it as zero
    if (NO_CS_FIELD) begin : g_no_cs
        assign cs_code = '0;
    end else begin : g_cs
        assign cs_code = code_arr[0];
    end

    // Hazard substitution: prohibited power-down becomes self-refresh
    always_comb begin
        eff_mode = mode_i;
        if (PD_BLOCKED && (mode_i == MODE_PWRDN)) eff_mode = MODE_SELFREF;
    end

    always_comb begin
        lp_en    = 1'b0;
        sel_code = '0;
        unique case (eff_mode)
            MODE_CLKSTOP: begin lp_en = 1'b1; sel_code = cs_code;     end
            MODE_SELFREF: begin lp_en = 1'b1; sel_code = code_arr[1]; end
            MODE_PWRDN:   begin lp_en = 1'b1; sel_code = code_arr[2]; end
            default:      begin lp_en = 1'b0; sel_code = '0;          end
        endcase
    end

    assign cfg.pd   = code_arr[2];
    assign cfg.rsvd = 1'b0;
    assign cfg.mode = eff_mode;
    assign cfg.sr   = code_arr[1];
    assign cfg.cs   = cs_code;
    assign cfg_o    = cfg;

    lp_idle_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_ACTIVE),
        .req_i     (req_i),
        .code_i    (sel_code),
        .expired_o (expired)
    );

    assign go_lp = lp_en && expired &&
                   !((eff_mode == MODE_SELFREF) && freq_chg_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:    if (go_lp) state_d = ST_LOWPWR;
            ST_LOWPWR:    if (req_i) state_d = ST_EXIT_WAIT;
            ST_EXIT_WAIT: if (wait_q == '0)
                              state_d = (lp_mode_q == MODE_PWRDN) ? ST_ZQ_CAL : ST_ACTIVE;
            ST_ZQ_CAL:    if (zq_done_i) state_d = ST_ACTIVE;
            default:      state_d = ST_ACTIVE;
        endcase
    end

    // State register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ACTIVE;
            lp_mode_q <= MODE_OFF;
            wait_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_ACTIVE) && go_lp)
                lp_mode_q <= eff_mode;
            if ((state_q == ST_LOWPWR) && req_i)
                wait_q <= exit_wait_i;
            else if ((state_q == ST_EXIT_WAIT) && (wait_q != '0))
                wait_q <= wait_q - WAIT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        grant_o    = 1'b0;
        enter_cs_o = 1'b0;
        enter_sr_o = 1'b0;
        enter_pd_o = 1'b0;
        exit_cs_o  = 1'b0;
        exit_sr_o  = 1'b0;
        exit_pd_o  = 1'b0;
        zq_req_o   = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                grant_o = req_i;
                if (go_lp) begin
                    enter_cs_o = (eff_mode == MODE_CLKSTOP);
                    enter_sr_o = (eff_mode == MODE_SELFREF);
                    enter_pd_o = (eff_mode == MODE_PWRDN);
                end
            end
            ST_LOWPWR: begin
                if (req_i) begin
                    exit_cs_o = (lp_mode_q == MODE_CLKSTOP);
                    exit_sr_o = (lp_mode_q == MODE_SELFREF);
                    exit_pd_o = (lp_mode_q == MODE_PWRDN);
                end
            end
            ST_EXIT_WAIT: ;
            ST_ZQ_CAL:    zq_req_o = 1'b1;
            default:      ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/lp_idle_ctrl_chk.sv
module lp_idle_ctrl_chk #(
    parameter bit PD_BLOCKED  = 1'b0,
    parameter bit NO_CS_FIELD = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode_i,
    input logic        req_i,
    input logic        freq_chg_i,
    input logic        zq_done_i,
    input logic        grant_o,
    input logic        enter_cs_o,
    input logic        exit_cs_o,
    input logic        enter_sr_o,
    input logic        exit_sr_o,
    input logic        enter_pd_o,
    input logic        exit_pd_o,
    input logic        zq_req_o,
    input logic [15:0] cfg_o
);
    p_no_sr_entry_freq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freq_chg_i |-> !enter_sr_o);

    p_off_no_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0) |-> !(enter_cs_o || enter_sr_o || enter_pd_o));

    p_pulse_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_cs_o, exit_cs_o, enter_sr_o, exit_sr_o, enter_pd_o, exit_pd_o}));

    p_zq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zq_req_o && !zq_done_i) |=> zq_req_o);

    p_zq_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zq_req_o |-> !grant_o);

    p_exit_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_cs_o || exit_sr_o || exit_pd_o) |=> !grant_o);

    p_grant_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> req_i);

    if (PD_BLOCKED) begin : g_pd
        p_no_pd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !enter_pd_o);
    end

    if (NO_CS_FIELD) begin : g_cs
        p_cs_field_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_o[3:0] == 4'd0);
    end
endmodule

bind lp_idle_ctrl lp_idle_ctrl_chk #(
    .PD_BLOCKED  (PD_BLOCKED),
    .NO_CS_FIELD (NO_CS_FIELD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .req_i      (req_i),
    .freq_chg_i (freq_chg_i),
    .zq_done_i  (zq_done_i),
    .grant_o    (grant_o),
    .enter_cs_o (enter_cs_o),
    .exit_cs_o  (exit_cs_o),
    .enter_sr_o (enter_sr_o),
    .exit_sr_o  (exit_sr_o),
    .enter_pd_o (enter_pd_o),
    .exit_pd_o  (exit_pd_o),
    .zq_req_o   (zq_req_o),
    .cfg_o      (cfg_o)
);

// File: tb/lp_idle_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_idle_ctrl_tb_top;
    localparam int TMO_W  = 20;
    localparam int WAIT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [TMO_W-1:0] cs_raw = '0, sr_raw = '0, pd_raw = '0;
    logic [WAIT_W-1:0] ewait = '0;
    logic req = 1'b0, freq = 1'b0, zq_done = 1'b0;

    logic grant, en_cs, ex_cs, en_sr, ex_sr, en_pd, ex_pd, zq_req;
    logic [2:0] st;
    logic [15:0] cfg;
    logic v_grant, v_en_cs, v_ex_cs, v_en_sr, v_ex_sr, v_en_pd, v_ex_pd, v_zq;
    logic [2:0] v_st;
    logic [15:0] v_cfg;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lp_idle_ctrl #(.TMO_W(TMO_W), .WAIT_W(WAIT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .cs_cycles_i(cs_raw), .sr_cycles_i(sr_raw), .pd_cycles_i(pd_raw),
        .exit_wait_i(ewait), .req_i(req), .freq_chg_i(freq), .zq_done_i(zq_done),
        .grant_o(grant), .enter_cs_o(en_cs), .exit_cs_o(ex_cs),
        .enter_sr_o(en_sr), .exit_sr_o(ex_sr), .enter_pd_o(en_pd), .exit_pd_o(ex_pd),
        .zq_req_o(zq_req), .state_o(st), .cfg_o(cfg)
    );

    lp_idle_ctrl #(.TMO_W(TMO_W), .WAIT_W(WAIT_W), .PD_BLOCKED(1'b1), .NO_CS_FIELD(1'b1)) dut_v (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .cs_cycles_i(cs_raw), .sr_cycles_i(sr_raw), .pd_cycles_i(pd_raw),
        .exit_wait_i(ewait), .req_i(req), .freq_chg_i(freq), .zq_done_i(zq_done),
        .grant_o(v_grant), .enter_cs_o(v_en_cs), .exit_cs_o(v_ex_cs),
        .enter_sr_o(v_en_sr), .exit_sr_o(v_ex_sr), .enter_pd_o(v_en_pd), .exit_pd_o(v_ex_pd),
        .zq_req_o(v_zq), .state_o(v_st), .cfg_o(v_cfg)
    );

    task automatic check(input string rq, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic pick_enter(input logic [2:0] m);
        case (m)
            3'd1:    return en_cs;
            3'd2:    return en_sr;
            default: return en_pd;
        endcase
    endfunction

    function automatic logic pick_exit(input logic [2:0] m);
        case (m)
            3'd1:    return ex_cs;
            3'd2:    return ex_sr;
            default: return ex_pd;
        endcase
    endfunction

    // One access cycle, then idle; returns in the first idle cycle (sampled phase)
    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        #1;
    endtask

    // Count idle cycles until any enter pulse appears (1 = first idle cycle)
    task automatic measure(output int j);
        j = 1;
        while (!(en_cs || en_sr || en_pd) && j < 2000) begin
            @(negedge clk); #1; j++;
        end
    endtask

    task automatic leave_lp(input logic [2:0] m, input int w, input string rq);
        int first_g = -1;
        int first_z = -1;
        @(negedge clk); ewait = WAIT_W'(w); req = 1'b1; #1;
        check({rq, " exit pulse"}, pick_exit(m), 1);
        for (int k = 1; k <= w + 12; k++) begin
            @(negedge clk);
            zq_done = (m == 3'd4) && (k == w + 7);
            #1;
            if (grant && first_g < 0) first_g = k;
            if (zq_req && first_z < 0) first_z = k;
        end
        if (m == 3'd4) begin
            check({rq, " zq request cycle"}, first_z, w + 2);
            check({rq, " grant after zq done"}, first_g, w + 8);
        end else begin
            check({rq, " grant cycle"}, first_g, w + 2);
            check({rq, " no zq request"}, first_z, -1);
        end
        @(negedge clk); req = 1'b0; zq_done = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 state", st, 0);
        check("R1 pulses", {en_cs, ex_cs, en_sr, ex_sr, en_pd, ex_pd, zq_req}, 0);
        check("R1 grant", grant, 0);
    endtask

    task automatic t_encode();
        @(negedge clk); mode = 3'd2; cs_raw = 20'd10; sr_raw = 20'd16; pd_raw = 20'd100; #1;
        check("R2 cs small->0", cfg[3:0], 0);
        check("R2 sr 16->1", cfg[7:4], 1);
        check("R2 pd 100->4", cfg[15:12], 4);
        check("R2 mode field", cfg[10:8], 2);
        check("R2 bit11", cfg[11], 0);
        @(negedge clk); cs_raw = 20'd262144; sr_raw = 20'd262145; pd_raw = 20'hFFFFF; #1;
        check("R2 cs 2^18->15", cfg[3:0], 15);
        check("R2 sr sat", cfg[7:4], 15);
        check("R2 pd sat", cfg[15:12], 15);
        check("R10 variant cs field zero", v_cfg[3:0], 0);
        @(negedge clk); sr_raw = 20'd17; pd_raw = 20'd64; mode = 3'd4; #1;
        check("R2 sr 17->2", cfg[7:4], 2);
        check("R2 pd 64->3", cfg[15:12], 3);
        check("R11 pd mode code", cfg[10:8], 4);
        check("R9 variant substitutes sr", v_cfg[10:8], 2);
    endtask

    task automatic t_entry(input logic [2:0] m, input int exp_j, input int w, input string rq);
        int j;
        @(negedge clk); mode = m;
        pulse_req();
        measure(j);
        check({rq, " entry cycle"}, j, exp_j);
        check({rq, " enter pulse of mode"}, pick_enter(m), 1);
        @(negedge clk); #1;
        check("R11 state lowpwr", st, 1);
        leave_lp(m, w, rq);
    endtask

    task automatic t_restart();
        int j;
        int seen = 0;
        @(negedge clk); mode = 3'd2; sr_raw = 20'd16;
        pulse_req();
        for (int k = 0; k < 10; k++) begin
            if (en_sr) seen++;
            @(negedge clk); #1;
        end
        check("R4 no entry before timeout", seen, 0);
        pulse_req();
        measure(j);
        check("R4 count restarts after access", j, 16);
        @(negedge clk);
        leave_lp(3'd2, 1, "R4");
    endtask

    task automatic t_disable();
        int seen = 0;
        @(negedge clk); mode = 3'd0; sr_raw = 20'd10; cs_raw = 20'd10; pd_raw = 20'd10;
        pulse_req();
        for (int k = 0; k < 300; k++) begin
            if (en_cs || en_sr || en_pd || st != 3'd0) seen++;
            @(negedge clk); #1;
        end
        check("R5 mode 0 stays active", seen, 0);
        @(negedge clk); mode = 3'd3; #1;
        for (int k = 0; k < 100; k++) begin
            if (en_cs || en_sr || en_pd || st != 3'd0) seen++;
            @(negedge clk); #1;
        end
        check("R5 unused code stays active", seen, 0);
    endtask

    task automatic t_freq();
        int seen = 0;
        int j;
        @(negedge clk); mode = 3'd2; sr_raw = 20'd16; freq = 1'b1;
        pulse_req();
        for (int k = 0; k < 40; k++) begin
            if (en_sr || st != 3'd0) seen++;
            @(negedge clk); #1;
        end
        check("R8 sr held off during freq change", seen, 0);
        @(negedge clk); freq = 1'b0; #1;
        check("R8 sr entry on release", en_sr, 1);
        @(negedge clk); #1;
        check("R8 lowpwr after release", st, 1);
        leave_lp(3'd2, 0, "R8");
        @(negedge clk); mode = 3'd1; cs_raw = 20'd10; freq = 1'b1;
        pulse_req();
        measure(j);
        check("R8 clock stop not held off", j, 8);
        check("R8 clock stop pulse", en_cs, 1);
        @(negedge clk); freq = 1'b0;
        leave_lp(3'd1, 2, "R8");
    endtask

    task automatic t_variant();
        int j;
        @(negedge clk); mode = 3'd4; sr_raw = 20'd16; pd_raw = 20'd16;
        pulse_req();
        measure(j);
        check("R9 main pd entry cycle", j, 16);
        check("R9 main pd pulse", en_pd, 1);
        check("R9 variant sr pulse", v_en_sr, 1);
        check("R9 variant no pd pulse", v_en_pd, 0);
        @(negedge clk);
        leave_lp(3'd4, 2, "R9");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_encode();
        ewait = 8'd3;
        cs_raw = 20'd10; sr_raw = 20'd16; pd_raw = 20'd64;
        t_entry(3'd1, 8, 3, "R3 clock stop");
        t_entry(3'd2, 16, 0, "R3 self-refresh");
        t_entry(3'd4, 64, 5, "R7 power-down");
        t_restart();
        t_disable();
        t_freq();
        t_variant();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule